// File: doc/BRIEF.md
# Two-Bit Direction Table with Branch Target Buffer

This block predicts branches at the fetch stage. Each fetch PC is looked up in the same cycle in two direct-mapped structures. The first is a table of 2-bit saturating direction counters. The second is a small target buffer whose entries hold a valid bit, an address tag and a target address. When the buffer hits and the counter leans taken, the block returns the stored target as the next fetch address. In every other case it returns the fall-through address, PC+4. Steering fetch to a known target in the lookup cycle removes the bubble a taken branch would otherwise cost.

When a branch resolves further down the pipeline, its PC, its actual direction and its actual target come back on the update channel. The counter at that PC's index moves one step toward the outcome. A taken outcome also writes the buffer entry with the branch's tag and target, replacing whatever was there. Flushing the pipeline and choosing the recovery PC are handled outside this block.

Both channels carry valid only. The block accepts a lookup and an update in every cycle and never applies back-pressure. The prediction is combinational from the lookup inputs, and `pd_valid` follows `lk_valid` in the same cycle. An update takes effect at the next rising clock edge.

Top module: `bpred_top`

## Requirements
- R1: After reset every direction counter holds weakly-not-taken (01) and every buffer entry is invalid, so any lookup predicts not taken with next PC = PC+4.
- R2: Counter encoding: 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken. A resolved taken outcome increments the indexed counter and a not-taken outcome decrements it, saturating at 11 and at 00.
- R3: A lookup predicts taken, with next PC equal to the stored target, exactly when the buffer entry is valid, its tag equals the PC's upper bits, and the counter's upper bit is 1.
- R4: On a buffer hit whose counter reads 00 or 01, the next PC is the fall-through address PC+4.
- R5: On a buffer miss (entry invalid or tag mismatch), the next PC is PC+4 whatever the counter holds.
- R6: A resolved taken branch writes its buffer entry with valid, tag and target, overwriting the entry. A not-taken resolution leaves every buffer entry unchanged.
- R7: A lookup in the same cycle as an update to the same index sees the state before that update. The update is visible from the next cycle.
- R8: A branch whose counter is strongly taken keeps predicting taken after one not-taken outcome, and flips only after a second consecutive one.
- R9: `pd_valid` equals `lk_valid` in the same cycle, and `pd_taken` is 0 whenever `lk_valid` is 0.
- R10: PC bits 1:0 take no part in indexing or tagging. The counter index is PC[IDX_W+1:2], the buffer index is PC[BTB_IDX_W+1:2], and the tag is PC[PC_W-1:BTB_IDX_W+2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request present |
| lk_pc | input | PC_W | Fetch PC to predict |
| pd_valid | output | 1 | Prediction present (follows lk_valid) |
| pd_taken | output | 1 | Predicted taken with a known target |
| pd_next_pc | output | PC_W | Next fetch address (target or PC+4) |
| up_valid | input | 1 | Resolved branch present |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Actual direction |
| up_target | input | PC_W | Actual target address |

## Verification
The bench targets several corner cases. With two PCs that share a buffer index but carry different tags, a design that skips the tag compare redirects to another branch's target. A strongly-taken branch that sees a single not-taken outcome must keep predicting taken; a one-bit or wrapping counter flips too early or jumps to the wrong state. A lookup and an update to the same index in one cycle must return the old state, which a write-through design gets wrong. A not-taken resolution must leave the buffer alone, or a live target is lost. A long pseudo-random mix of lookups and updates over aliasing addresses, with the low PC bits set, is compared against a behavioural model every cycle and exposes saturation or indexing slips.

// File: rtl/bpred_pkg.sv
package bpred_pkg;

  typedef enum logic [1:0] {
    CNT_SNT = 2'b00,
    CNT_WNT = 2'b01,
    CNT_WT  = 2'b10,
    CNT_ST  = 2'b11
  } cnt_t;

  // Move one step toward the resolved direction, saturating at both ends.
  function automatic cnt_t cnt_step(cnt_t cur, logic taken);
    cnt_t nxt;
    nxt = cur;
    if (taken) begin
      if (cur != CNT_ST) nxt = cnt_t'(cur + 2'd1);
    end else begin
      if (cur != CNT_SNT) nxt = cnt_t'(cur - 2'd1);
    end
    return nxt;
  endfunction

endpackage

// File: rtl/bpred_dir_table.sv
module bpred_dir_table
  import bpred_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] rd_pc,
  output cnt_t            rd_cnt,
  input  logic            wr_en,
  input  logic [PC_W-1:0] wr_pc,
  input  logic            wr_taken
);

  localparam int DEPTH = 1 << IDX_W;

  logic [IDX_W-1:0] rd_idx;
  logic [IDX_W-1:0] wr_idx;
  cnt_t             tbl [DEPTH];

  assign rd_idx = rd_pc[IDX_W+1:2];
  assign wr_idx = wr_pc[IDX_W+1:2];

  logic unused_pc_bits;
  assign unused_pc_bits = ^{rd_pc[PC_W-1:IDX_W+2], rd_pc[1:0],
                            wr_pc[PC_W-1:IDX_W+2], wr_pc[1:0]};

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tbl[g] <= CNT_WNT;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        tbl[g] <= cnt_step(tbl[g], wr_taken);
      end
    end
  end

  assign rd_cnt = tbl[rd_idx];

  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken && tbl[wr_idx] == CNT_ST) |=> tbl[$past(wr_idx)] == CNT_ST); // R2

  AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_taken && tbl[wr_idx] == CNT_SNT) |=> tbl[$past(wr_idx)] == CNT_SNT); // R2

  AST_ONE_MISS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_taken && tbl[wr_idx] == CNT_ST) |=> tbl[$past(wr_idx)] == CNT_WT); // R8

endmodule

// File: rtl/bpred_tgt_buf.sv
module bpred_tgt_buf #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] rd_pc,
  output logic            rd_hit,
  output logic [PC_W-1:0] rd_tgt,
  input  logic            wr_en,
  input  logic [PC_W-1:0] wr_pc,
  input  logic [PC_W-1:0] wr_tgt
);

  localparam int DEPTH = 1 << IDX_W;
  localparam int TAG_W = PC_W - 2 - IDX_W;

  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic [TAG_W-1:0] rd_tag, wr_tag;

  logic [DEPTH-1:0] vld;
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [PC_W-1:0]  tgt_q [DEPTH];

  assign rd_idx = rd_pc[IDX_W+1:2];
  assign wr_idx = wr_pc[IDX_W+1:2];
  assign rd_tag = rd_pc[PC_W-1:IDX_W+2];
  assign wr_tag = wr_pc[PC_W-1:IDX_W+2];

  logic unused_pc_bits;
  assign unused_pc_bits = ^{rd_pc[1:0], wr_pc[1:0]};

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld[g]   <= 1'b0;
        tag_q[g] <= '0;
        tgt_q[g] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        vld[g]   <= 1'b1;
        tag_q[g] <= wr_tag;
        tgt_q[g] <= wr_tgt;
      end
    end
  end

  assign rd_hit = vld[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign rd_tgt = tgt_q[rd_idx];

  AST_ALLOC_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (vld[$past(wr_idx)] && tgt_q[$past(wr_idx)] == $past(wr_tgt))); // R6

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(vld)); // R6

endmodule

// File: rtl/bpred_top.sv
module bpred_top
  import bpred_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int IDX_W     = 6,
  parameter int BTB_IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid,
  input  logic [PC_W-1:0] lk_pc,
  output logic            pd_valid,
  output logic            pd_taken,
  output logic [PC_W-1:0] pd_next_pc,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken,
  input  logic [PC_W-1:0] up_target
);

  localparam logic [PC_W-1:0] INSN_BYTES = PC_W'(4);

  cnt_t            lk_cnt;
  logic            lk_hit;
  logic [PC_W-1:0] lk_tgt;
  logic [PC_W-1:0] fall_pc;

  bpred_dir_table #(.PC_W(PC_W), .IDX_W(IDX_W)) u_dir (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_pc    (lk_pc),
    .rd_cnt   (lk_cnt),
    .wr_en    (up_valid),
    .wr_pc    (up_pc),
    .wr_taken (up_taken)
  );

  bpred_tgt_buf #(.PC_W(PC_W), .IDX_W(BTB_IDX_W)) u_btb (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_pc  (lk_pc),
    .rd_hit (lk_hit),
    .rd_tgt (lk_tgt),
    .wr_en  (up_valid && up_taken),
    .wr_pc  (up_pc),
    .wr_tgt (up_target)
  );

  assign fall_pc = lk_pc + INSN_BYTES;

  always_comb begin
    pd_valid   = lk_valid;
    pd_taken   = lk_valid && lk_hit && lk_cnt[1];
    pd_next_pc = pd_taken ? lk_tgt : fall_pc;
  end

  AST_NO_PRED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !pd_taken); // R9

  AST_TAKEN_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    pd_taken |-> (lk_hit && lk_cnt inside {CNT_WT, CNT_ST})); // R3

  AST_MISS_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_hit) |-> pd_next_pc == lk_pc + INSN_BYTES); // R5

endmodule

// File: tb/bpred_top_tb.sv
module bpred_top_tb;

  localparam int PC_W = 32;
  localparam int IDX_W = 6;
  localparam int BTB_IDX_W = 4;
  localparam int NCNT = 1 << IDX_W;
  localparam int NBTB = 1 << BTB_IDX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0;
  logic [PC_W-1:0] lk_pc = '0;
  logic pd_valid, pd_taken;
  logic [PC_W-1:0] pd_next_pc;
  logic up_valid = 1'b0;
  logic [PC_W-1:0] up_pc = '0;
  logic up_taken = 1'b0;
  logic [PC_W-1:0] up_target = '0;

  always #10 clk = ~clk;

  bpred_top #(.PC_W(PC_W), .IDX_W(IDX_W), .BTB_IDX_W(BTB_IDX_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_pc(lk_pc),
    .pd_valid(pd_valid), .pd_taken(pd_taken), .pd_next_pc(pd_next_pc),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken), .up_target(up_target)
  );

  // Behavioural reference state
  int m_cnt [NCNT];
  bit m_vld [NBTB];
  int unsigned m_tag [NBTB];
  int unsigned m_tgt [NBTB];

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  function automatic int unsigned cidx(int unsigned pc);
    return (pc >> 2) % NCNT;
  endfunction
  function automatic int unsigned bidx(int unsigned pc);
    return (pc >> 2) % NBTB;
  endfunction
  function automatic int unsigned btag(int unsigned pc);
    return pc >> (2 + BTB_IDX_W);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NCNT; i++) m_cnt[i] = 1;
    for (int i = 0; i < NBTB; i++) begin
      m_vld[i] = 0; m_tag[i] = 0; m_tgt[i] = 0;
    end
  endtask

  task automatic step(input bit lv, input int unsigned lpc,
                      input bit uv, input int unsigned upc, input bit ut,
                      input int unsigned utgt, input string req);
    bit e_tk;
    int unsigned e_pc;
    @(negedge clk);
    lk_valid = lv; lk_pc = lpc;
    up_valid = uv; up_pc = upc; up_taken = ut; up_target = utgt;
    #2;
    e_tk = lv && m_vld[bidx(lpc)] && (m_tag[bidx(lpc)] == btag(lpc)) && (m_cnt[cidx(lpc)] >= 2);
    e_pc = e_tk ? m_tgt[bidx(lpc)] : lpc + 4;
    checks++;
    if (pd_valid !== lv || pd_taken !== e_tk || (lv && pd_next_pc !== e_pc)) begin
      fails++;
      $display("FAIL %s pc=%h: valid=%b taken=%b next=%h expected valid=%b taken=%b next=%h",
               req, lpc, pd_valid, pd_taken, pd_next_pc, lv, e_tk, e_pc);
    end
    @(posedge clk);
    if (uv) begin
      if (ut && m_cnt[cidx(upc)] < 3) m_cnt[cidx(upc)]++;
      if (!ut && m_cnt[cidx(upc)] > 0) m_cnt[cidx(upc)]--;
      if (ut) begin
        m_vld[bidx(upc)] = 1; m_tag[bidx(upc)] = btag(upc); m_tgt[bidx(upc)] = utgt;
      end
    end
  endtask

  task automatic look(input int unsigned pc, input string req);
    step(1, pc, 0, 0, 0, 0, req);
  endtask
  task automatic upd(input int unsigned pc, input bit t, input int unsigned tgt, input string req);
    step(0, 0, 1, pc, t, tgt, req);
  endtask

  initial begin
    #3_000_000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  localparam int unsigned PA = 32'h0000_0100; // counter idx 0, buffer idx 0
  localparam int unsigned PB = 32'h0000_0140; // buffer idx 0, other tag
  localparam int unsigned TA = 32'h0000_2000;
  localparam int unsigned TB = 32'h0000_3000;

  initial begin
    int unsigned lfsr;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state
    look(PA, "R1"); look(32'h0000_0ffc, "R1"); look(32'h1234_5678, "R1");
    // R9: idle lookup
    step(0, PA, 0, 0, 0, 0, "R9");
    // R7: lookup and taken update same index, same cycle -> old state
    step(1, PA, 1, PA, 1, TA, "R7");
    // R3: now hit with counter 10
    look(PA, "R3");
    upd(PA, 1, TA, "R2");               // counter 11
    look(PA, "R3");
    upd(PA, 0, 0, "R8"); look(PA, "R8"); // 10 still taken
    upd(PA, 0, 0, "R8"); look(PA, "R4"); // 01 falls through on a hit
    upd(PA, 0, 0, "R2"); upd(PA, 0, 0, "R2"); look(PA, "R2"); // saturate 00
    upd(PA, 1, TA, "R2"); upd(PA, 1, TA, "R2"); upd(PA, 1, TA, "R2");
    upd(PA, 1, TA, "R2"); look(PA, "R2");      // 11
    // R6: not-taken on aliasing PC leaves buffer entry alone
    upd(PB, 0, 0, "R6"); look(PA, "R6");
    // R9: would be taken, but lookup not valid
    step(0, PA, 0, 0, 0, 0, "R9");
    // R6/R5: taken on PB overwrites entry; PA now misses on tag
    upd(PB, 1, TB, "R6"); look(PA, "R5"); look(PB, "R4");
    upd(PB, 1, TB, "R6"); look(PB, "R3");
    // R10: low PC bits ignored
    look(PB + 1, "R10"); look(PB + 3, "R10");
    upd(PB + 2, 0, 0, "R10"); look(PB, "R10");
    // R7: same-cycle not-taken update returns old prediction
    step(1, PB, 1, PB, 0, 0, "R7"); look(PB, "R7");

    // Mixed pseudo-random traffic over a narrow address range (aliasing)
    lfsr = 32'hACE1_1234;
    for (int i = 0; i < 3000; i++) begin
      int unsigned a, b;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      a = (lfsr & 32'h0000_0fff) | 32'h0001_0000;
      b = ((lfsr >> 12) & 32'h0000_0fff) | 32'h0001_0000;
      if (lfsr[31]) b = a;
      step(lfsr[20] | lfsr[21], a, lfsr[22], b, lfsr[23] | lfsr[24], lfsr ^ 32'h5a5a_0000, "R2");
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule